// File: doc/BRIEF.md
# Descriptor-Driven I/O Channel

This block is a small I/O processor channel that moves blocks of words between a device port and main memory without the CPU handling each word. The CPU starts the channel with one request that names a device and gives the word address of a command block in memory. The channel reads that block over its memory bus port and decodes the command. It then copies the data word by word, using bus cycles for each word, and raises an interrupt when the command is finished.

A command block is four consecutive 32-bit memory words. The first holds the operation code, the second the buffer start address, the third the word count, and the fourth a set of request flags. All memory accesses are single-word, word-addressed reads or writes. Each access uses a request/acknowledge handshake.

Top module: `ioch_channel`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `irq`, `mem_req`, `dev_rd` and `dev_wr` are low.
- R2: A `start_valid` seen while `busy` is low is accepted: the channel latches `start_dev` onto `dev_sel` and `start_ptr` as the block address. A `start_valid` seen while `busy` is high has no effect on the running command, on `dev_sel`, or on what follows.
- R3: The command block is read first, as four reads (`mem_we` low) at block address +0, +1, +2 and +3, in that order. Their words are taken as opcode, buffer address (low address bits), count (low 16 bits) and flags.
- R4: Opcode value 1 (device to memory): for word i, the channel takes one word from the device (a `dev_rd` cycle samples `dev_rdata`). It then writes that word to memory at buffer address + i, with i running upward from 0.
- R5: Opcode value 2 (memory to device): for word i, the channel reads memory at buffer address + i. It then presents the word on `dev_wdata` with a one-cycle `dev_wr` pulse while `dev_sel` names the started device.
- R6: A count of zero moves no words: there is no `dev_rd`, no `dev_wr` and no memory write, and the command completes right after the block is read.
- R7: Any opcode other than 1 or 2 moves no words. It completes with an interrupt and with `irq_err` = 1. `irq_err` keeps its value until the next accepted start, which clears it.
- R8: Flags bit 0 set suppresses the completion interrupt of a valid command. An error completion interrupts regardless of that bit.
- R9: Assume a memory that raises `mem_ack` for one cycle, on the edge after it first sees `mem_req`. Under that memory, for N words moved, `irq` is high for exactly one cycle, which begins 12 + 3N clock edges after the edge that accepted the start. `busy` falls one edge later.
- R10: Once `mem_req` is raised, it and `mem_addr`, `mem_we` and `mem_wdata` stay stable until the edge on which `mem_ack` is seen. `mem_req` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | CPU start request |
| start_dev | input | DEV_W | Device number for the command |
| start_ptr | input | ADDR_W | Word address of the command block |
| busy | output | 1 | A command is in progress |
| irq | output | 1 | One-cycle completion interrupt |
| irq_err | output | 1 | Last command ended with a bad opcode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| dev_sel | output | DEV_W | Selected device |
| dev_rd | output | 1 | Device word taken this cycle |
| dev_rdata | input | DATA_W | Word offered by the device |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DATA_W | Word written to the device |

## Verification
Under the one-cycle-acknowledge memory, each access takes three edges: issue, acknowledge, then the channel seeing the acknowledge. So `irq` is due 12 + 3N edges after the start edge, and `busy` is due to drop one edge after that. The bench keeps a behavioural model that counts edges from the accepted start. At every falling edge it compares `busy`, `irq` and `irq_err` against that model, so an early, late or missing interrupt is caught in the exact cycle it goes wrong. Data, address order and device activity are checked once each command has finished, from logs the bench memory and device models build.

// File: rtl/ioch_pkg.sv
package ioch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_FETCH2,
    ST_FETCH3,
    ST_EXEC,
    ST_DONE
  } ioch_state_e;

  localparam int OPC_DEV2MEM = 1;
  localparam int OPC_MEM2DEV = 2;
  localparam int DESC_WORDS  = 4;
  localparam int FLAG_NOIRQ  = 0;
endpackage

// File: rtl/ioch_desc_store.sv
module ioch_desc_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [DATA_W-1:0] cap_word,
  output logic [DATA_W-1:0] op_o,
  output logic [ADDR_W-1:0] buf_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              noirq_o
);
  import ioch_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_o    <= '0;
      buf_o   <= '0;
      cnt_o   <= '0;
      noirq_o <= 1'b0;
    end else if (cap_en) begin
      case (cap_idx)
        IDX_W'(0): op_o    <= cap_word;
        IDX_W'(1): buf_o   <= cap_word[ADDR_W-1:0];
        IDX_W'(2): cnt_o   <= cap_word[CNT_W-1:0];
        default:   noirq_o <= cap_word[FLAG_NOIRQ];
      endcase
    end
  end
endmodule

// File: rtl/ioch_walker.sv
module ioch_walker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem_q    <= '0;
    end else if (load) begin
      cur_addr <= base;
      rem_q    <= count;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(1);
      rem_q    <= rem_q - CNT_W'(1);
    end
  end

  assign last = (rem_q == CNT_W'(1));
endmodule

// File: rtl/ioch_channel.sv
module ioch_channel #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [DEV_W-1:0]  start_dev,
  input  logic [ADDR_W-1:0] start_ptr,
  output logic              busy,
  output logic              irq,
  output logic              irq_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DEV_W-1:0]  dev_sel,
  output logic              dev_rd,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              dev_wr,
  output logic [DATA_W-1:0] dev_wdata
);
  import ioch_pkg::*;

  localparam int IDX_W = $clog2(DESC_WORDS);

  ioch_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  fidx;
  logic              in_fetch;
  logic              acked;
  logic [DATA_W-1:0] op_w;
  logic [ADDR_W-1:0] buf_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              noirq_w;
  logic [ADDR_W-1:0] walk_addr;
  logic              walk_last;
  logic              op_d2m;
  logic              op_ok;

  always_comb begin
    case (state_q)
      ST_FETCH1: fidx = IDX_W'(1);
      ST_FETCH2: fidx = IDX_W'(2);
      ST_FETCH3: fidx = IDX_W'(3);
      default:   fidx = IDX_W'(0);
    endcase
  end

  assign in_fetch = (state_q == ST_FETCH0) || (state_q == ST_FETCH1) ||
                    (state_q == ST_FETCH2) || (state_q == ST_FETCH3);
  assign acked    = mem_req && mem_ack;
  assign op_d2m   = (op_w == DATA_W'(OPC_DEV2MEM));
  assign op_ok    = op_d2m || (op_w == DATA_W'(OPC_MEM2DEV));
  assign busy     = (state_q != ST_IDLE);
  assign dev_rd   = (state_q == ST_EXEC) && !mem_req && op_d2m;

  ioch_desc_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_desc (
    .clk(clk), .rst(rst),
    .cap_en(in_fetch && acked), .cap_idx(fidx), .cap_word(mem_rdata),
    .op_o(op_w), .buf_o(buf_w), .cnt_o(cnt_w), .noirq_o(noirq_w)
  );

  ioch_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst),
    .load((state_q == ST_FETCH3) && acked),
    .base(buf_w), .count(cnt_w),
    .step((state_q == ST_EXEC) && acked),
    .cur_addr(walk_addr), .last(walk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      dev_sel   <= '0;
      irq       <= 1'b0;
      irq_err   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dev_wr    <= 1'b0;
      dev_wdata <= '0;
    end else begin
      irq    <= 1'b0;
      dev_wr <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_valid) begin
            dev_sel <= start_dev;
            ptr_q   <= start_ptr;
            irq_err <= 1'b0;
            state_q <= ST_FETCH0;
          end
        end
        ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_FETCH3: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr_q + ADDR_W'(fidx);
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            case (state_q)
              ST_FETCH0: state_q <= ST_FETCH1;
              ST_FETCH1: state_q <= ST_FETCH2;
              ST_FETCH2: state_q <= ST_FETCH3;
              default: begin
                if (!op_ok) begin
                  irq_err <= 1'b1;
                  irq     <= 1'b1;
                  state_q <= ST_DONE;
                end else if (cnt_w == '0) begin
                  irq     <= !mem_rdata[FLAG_NOIRQ];
                  state_q <= ST_DONE;
                end else begin
                  state_q <= ST_EXEC;
                end
              end
            endcase
          end
        end
        ST_EXEC: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= op_d2m;
            mem_addr <= walk_addr;
            if (op_d2m) mem_wdata <= dev_rdata;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (!op_d2m) begin
              dev_wr    <= 1'b1;
              dev_wdata <= mem_rdata;
            end
            if (walk_last) begin
              irq     <= !noirq_w;
              state_q <= ST_DONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ioch_channel_chk.sv
module ioch_channel_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_valid,
  input logic              busy,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic [DEV_W-1:0]  dev_sel
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy && !irq && !mem_req && !dev_rd && !dev_wr));

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && start_valid) |=> $stable(dev_sel));

  assert_dev_read_feeds_write_R4: assert property (@(posedge clk) disable iff (rst)
    dev_rd |=> (mem_req && mem_we));

  assert_dev_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> ($past(mem_ack) && $past(mem_req) && !$past(mem_we)));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));

  assert_req_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);
endmodule

bind ioch_channel ioch_channel_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W)
) u_chk (
  .clk(clk), .rst(rst), .start_valid(start_valid), .busy(busy), .irq(irq),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_sel(dev_sel)
);

// File: tb/test_ioch_channel.sv
`timescale 1ns/1ps
module test_ioch_channel;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int DEV_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_valid = 1'b0;
  logic [DEV_W-1:0]  start_dev = '0;
  logic [ADDR_W-1:0] start_ptr = '0;
  logic              busy, irq, irq_err;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ack;
  logic [DATA_W-1:0] mem_rdata;
  logic [DEV_W-1:0]  dev_sel;
  logic              dev_rd, dev_wr;
  logic [DATA_W-1:0] dev_rdata, dev_wdata;

  always #2.5 clk = ~clk;

  ioch_channel i_ioch_channel (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_dev(start_dev),
    .start_ptr(start_ptr), .busy(busy), .irq(irq), .irq_err(irq_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges on the edge after it first sees a request
  logic [DATA_W-1:0] mem [0:255];
  logic              ack_r = 1'b0;
  logic [DATA_W-1:0] rd_r = '0;
  int                rd_log[$];
  int                wr_count = 0;
  assign mem_ack   = ack_r;
  assign mem_rdata = rd_r;

  always @(posedge clk) begin
    if (rst) ack_r <= 1'b0;
    else if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        rd_r <= mem[mem_addr[7:0]];
        rd_log.push_back(int'(mem_addr));
      end
    end else ack_r <= 1'b0;
  end

  // device model: source counts up, sink logs words and device number
  int pops = 0;
  logic [DATA_W-1:0] sink_q[$];
  int                sink_dev[$];
  assign dev_rdata = 32'hA000_0000 + DATA_W'(pops);
  always @(posedge clk) begin
    if (!rst && dev_rd) pops <= pops + 1;
    if (!rst && dev_wr) begin
      sink_q.push_back(dev_wdata);
      sink_dev.push_back(int'(dev_sel));
    end
  end

  // cycle-level reference model of busy / irq / irq_err
  int exp_n = 0;
  bit exp_irq_on = 1'b0;
  bit exp_err = 1'b0;
  bit m_active = 1'b0;
  int m_k = 0;
  int m_end = 0;
  bit m_irq_on = 1'b0;
  bit m_err = 1'b0;
  int irq_seen = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_active <= 1'b0;
      m_k <= 0;
      m_err <= 1'b0;
    end else if (!m_active && start_valid) begin
      m_active <= 1'b1;
      m_k <= 0;
      m_end <= 12 + 3 * exp_n;
      m_irq_on <= exp_irq_on;
      m_err <= exp_err;
    end else if (m_active) begin
      if (m_k == m_end) m_active <= 1'b0;
      else m_k <= m_k + 1;
    end
    if (!rst && irq) irq_seen <= irq_seen + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit irq_exp;
      irq_exp = m_active && (m_k == m_end) && m_irq_on;
      check(busy == m_active, "R9", "busy per cycle", longint'(busy), longint'(m_active));
      check(irq == irq_exp, "R9", "irq per cycle", longint'(irq), longint'(irq_exp));
      if (m_k == m_end || !m_active)
        check(irq_err == m_err, "R7", "irq_err", longint'(irq_err), longint'(m_err));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic put_desc(input int at, input int op, input int bufa, input int cnt,
                          input int flags);
    mem[at]   = DATA_W'(op);
    mem[at+1] = DATA_W'(bufa);
    mem[at+2] = DATA_W'(cnt);
    mem[at+3] = DATA_W'(flags);
  endtask

  task automatic run(input int dev, input int ptr, input int n, input bit irq_on,
                     input bit err);
    exp_n = n;
    exp_irq_on = irq_on;
    exp_err = err;
    rd_log.delete();
    @(negedge clk);
    start_valid = 1'b1;
    start_dev = DEV_W'(dev);
    start_ptr = ADDR_W'(ptr);
    @(negedge clk);
    start_valid = 1'b0;
    for (int w = 0; w < 1000 && busy; w++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_fetch(input int ptr);
    check(rd_log.size() >= 4, "R3", "descriptor read count",
          longint'(rd_log.size()), 4);
    for (int i = 0; i < 4 && i < rd_log.size(); i++)
      check(rd_log[i] == ptr + i, "R3", "descriptor read address",
            longint'(rd_log[i]), longint'(ptr + i));
  endtask

  initial begin
    int p0, w0, s0, q0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !irq && !mem_req && !dev_rd && !dev_wr, "R1", "outputs in reset",
          longint'({busy, irq, mem_req, dev_rd, dev_wr}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !irq && !mem_req, "R1", "outputs after reset",
          longint'({busy, irq, mem_req}), 0);

    // device to memory, 4 words
    put_desc(16, 1, 64, 4, 0);
    p0 = pops;
    run(3, 16, 4, 1'b1, 1'b0);
    check_fetch(16);
    check(pops - p0 == 4, "R4", "device words taken", longint'(pops - p0), 4);
    for (int i = 0; i < 4; i++)
      check(mem[64+i] == 32'hA000_0000 + DATA_W'(p0 + i), "R4", "memory word",
            longint'(mem[64+i]), longint'(32'hA000_0000 + DATA_W'(p0 + i)));

    // memory to device, 3 words
    for (int i = 0; i < 3; i++) mem[80+i] = 32'hC0DE_0000 + DATA_W'(i);
    put_desc(32, 2, 80, 3, 0);
    sink_q.delete(); sink_dev.delete();
    run(5, 32, 3, 1'b1, 1'b0);
    check_fetch(32);
    check(rd_log.size() == 7, "R5", "memory read count", longint'(rd_log.size()), 7);
    check(sink_q.size() == 3, "R5", "device writes", longint'(sink_q.size()), 3);
    for (int i = 0; i < 3 && i < sink_q.size(); i++) begin
      check(sink_q[i] == 32'hC0DE_0000 + DATA_W'(i), "R5", "device word",
            longint'(sink_q[i]), longint'(32'hC0DE_0000 + DATA_W'(i)));
      check(sink_dev[i] == 5, "R5", "device select", longint'(sink_dev[i]), 5);
    end

    // zero count
    put_desc(48, 1, 96, 0, 0);
    p0 = pops; w0 = wr_count; s0 = sink_q.size();
    run(2, 48, 0, 1'b1, 1'b0);
    check(pops == p0 && wr_count == w0 && sink_q.size() == s0, "R6",
          "no activity on zero count", longint'(pops - p0 + wr_count - w0), 0);

    // bad opcode
    put_desc(52, 7, 96, 2, 0);
    p0 = pops; w0 = wr_count; s0 = sink_q.size();
    run(1, 52, 0, 1'b1, 1'b1);
    check(pops == p0 && wr_count == w0 && sink_q.size() == s0, "R7",
          "no activity on bad opcode", longint'(pops - p0 + wr_count - w0), 0);
    check(irq_err == 1'b1, "R7", "error status held in idle", longint'(irq_err), 1);

    // interrupt suppressed by flag bit 0
    put_desc(56, 1, 100, 2, 1);
    q0 = irq_seen; p0 = pops;
    run(4, 56, 2, 1'b0, 1'b0);
    check(irq_seen == q0, "R8", "no interrupt with flag", longint'(irq_seen - q0), 0);
    check(mem[100] == 32'hA000_0000 + DATA_W'(p0) && mem[101] == 32'hA000_0000 + DATA_W'(p0 + 1),
          "R8", "transfer still done", longint'(mem[101]),
          longint'(32'hA000_0000 + DATA_W'(p0 + 1)));
    check(irq_err == 1'b0, "R7", "error cleared by start", longint'(irq_err), 0);

    // bad opcode with flag: still interrupts
    put_desc(60, 0, 100, 1, 1);
    q0 = irq_seen;
    run(4, 60, 0, 1'b1, 1'b1);
    check(irq_seen == q0 + 1, "R8", "error interrupts despite flag",
          longint'(irq_seen - q0), 1);

    // start while busy is ignored
    for (int i = 0; i < 2; i++) mem[120+i] = 32'h5EED_0000 + DATA_W'(i);
    put_desc(128, 2, 120, 2, 0);
    sink_q.delete(); sink_dev.delete();
    exp_n = 2; exp_irq_on = 1'b1; exp_err = 1'b0;
    @(negedge clk);
    start_valid = 1'b1; start_dev = 3'd6; start_ptr = 16'd128;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (5) @(negedge clk);
    start_valid = 1'b1; start_dev = 3'd1; start_ptr = 16'd32;
    @(negedge clk);
    start_valid = 1'b0;
    check(dev_sel == 3'd6, "R2", "device kept while busy", longint'(dev_sel), 6);
    for (int w = 0; w < 1000 && busy; w++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(!busy, "R2", "no second command", longint'(busy), 0);
    check(sink_q.size() == 2, "R2", "only first command moved",
          longint'(sink_q.size()), 2);
    for (int i = 0; i < 2 && i < sink_q.size(); i++)
      check(sink_q[i] == 32'h5EED_0000 + DATA_W'(i) && sink_dev[i] == 6, "R2",
            "first command data", longint'(sink_q[i]),
            longint'(32'h5EED_0000 + DATA_W'(i)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule